// File: doc/BRIEF.md
# Aux Table Mapping Updater

This engine edits a three-level translation table held in ordinary memory so that each 64 KiB page of a main-surface address range points at a block of auxiliary data. A command names the operation (install or remove), the page-aligned base, a byte length, the starting aux address and a format tag. The engine walks top, middle and leaf levels through a 64-bit memory port, one page at a time. It writes one leaf word for each page it installs, or clears the valid bit of each leaf it removes.

When a walk finds a missing upper level during an install, the engine carves a new table out of a bump allocator. It zeroes that table word by word and links it into its parent. The allocator works inside fixed-size backing buffers and asks its environment for a fresh buffer whenever the aligned request does not fit. The root table is carved the same way right after reset. Some edits mean cached copies of the table may be stale. The engine collects that condition over a whole command and reports it as one flush pulse when the command ends, with a running count beside it.

Top module: `aux_map_updater`

## Requirements
- R1: After reset the engine requests a buffer, carves a 32 KiB root table at its start, writes zero to every word of it, and only then raises `cmd_ready`; `root_base` then shows the root address.
- R2: An install writes, for each 64 KiB page while the byte offset is below the length, the leaf word `{fmt[11:0] at bits 63:52, aux bits 47:8 at 47:8, bit 0 = 1}`. The aux address grows by `AUX_STRIDE` (256) per page. Leaf index is address bits 23:16, middle index 35:24 and top index 47:36, each scaled by 8 bytes.
- R3: An invalid top entry (bit 0 clear) on an install causes a 32 KiB table, 32 KiB aligned, to be carved and zeroed. The top entry then becomes its address with bits 14:0 cleared, plus bit 0 set.
- R4: An invalid middle entry on an install causes an 8 KiB table, 8 KiB aligned, to be carved and zeroed. The middle entry then becomes its address with bits 12:0 cleared, plus bit 0 set.
- R5: When alignment padding plus table size exceeds what is left of the current buffer, `buf_req` is held until `buf_gnt`. The table is then placed at the start of the granted `buf_base`, and the allocator keeps bumping from there.
- R6: An install onto a leaf whose bit 0 is already set writes nothing to that leaf.
- R7: An install onto an invalid leaf whose bits 63:1 are non-zero and differ from the new word (with its valid bit) raises the flush condition. An identical or all-zero stale leaf does not.
- R8: A removal clears only bit 0 of a valid leaf and keeps all other bits and all upper tables. Pages whose top, middle or leaf entry is invalid cause no write and no allocation.
- R9: A removal that leaves a leaf word of all zeros raises the flush condition.
- R10: `flush_o` pulses at most once per command, in the same cycle as `done_o`, and `flush_cnt` grows by one exactly then.
- R11: A command whose base has any of bits 15:0 set, or whose aux address has any of bits 7:0 set, gets `err_o` and `done_o` for one cycle and makes no memory access.
- R12: A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. Read data on `mem_rdata` is used in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command may be taken |
| cmd_unmap | input | 1 | 1 = remove mappings, 0 = install |
| cmd_base | input | 48 | Main-surface base address |
| cmd_len | input | 32 | Range length in bytes |
| cmd_aux | input | 48 | Aux address for the first page |
| cmd_fmt | input | 12 | Format tag placed in leaf bits 63:52 |
| done_o | output | 1 | One-cycle pulse when a command ends |
| err_o | output | 1 | One-cycle pulse with done for a rejected command |
| flush_o | output | 1 | One-cycle pulse when table caches need a flush |
| flush_cnt | output | 16 | Number of flush pulses since reset |
| root_base | output | 48 | Address of the root table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 48 | Byte address of the 64-bit word |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after a read |
| buf_req | output | 1 | Request for a fresh backing buffer |
| buf_gnt | input | 1 | Buffer granted this cycle |
| buf_base | input | 48 | Base of the granted buffer |

## Verification
The first install runs into a region with no tables. It forces a middle and a leaf allocation, and with a small bench buffer it also forces a buffer switch, so the test tells placement, padding and linking apart from the leaf write. Repeating that install against a valid leaf shows the write is skipped. Partial removals followed by reinstalls with a changed aux address and with the same aux address separate the flush rule's two outcomes. An all-zero leaf cycled through install, remove and install covers the zero-payload flush and the zero-stale no-flush cases. Misaligned base and aux addresses, a removal over an unpopulated top index and a length that is not a page multiple mark the edges. After every command the bench compares every table word its reference has touched, buffers are filled with garbage on grant so that a missing clear shows up, and the write count is checked exactly.

// File: rtl/aux_upd_pkg.sv
package aux_upd_pkg;

   localparam int unsigned WORD_BYTES = 8;
   localparam int unsigned WORD_LG    = 3;

   typedef enum logic [3:0] {
      ST_BOOT,
      ST_ALLOC,
      ST_BUF,
      ST_CLEAR,
      ST_LINK,
      ST_IDLE,
      ST_RD_TOP,
      ST_CK_TOP,
      ST_RD_MID,
      ST_CK_MID,
      ST_RD_LEAF,
      ST_CK_LEAF,
      ST_STEP
   } upd_state_e;

   typedef enum logic [1:0] {
      LV_ROOT,
      LV_MID,
      LV_LEAF
   } tbl_level_e;

endpackage

// File: rtl/aux_bump_alloc.sv
module aux_bump_alloc #(
   parameter int unsigned AW        = 48,
   parameter int unsigned BUF_BYTES = 1048576
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] load_base_i,
   input  logic [AW-1:0] size_i,
   input  logic          commit_i,
   output logic          fit_o,
   output logic [AW-1:0] addr_o
);

   localparam logic [AW:0] BUF_SZ = (AW+1)'(BUF_BYTES);

   logic [AW:0] cur_q, lim_q;
   logic        have_q;
   logic [AW:0] sz_ext, sz_mask, aligned, alloc_end;

   generate
      if (BUF_BYTES < 8) begin : g_bad_buf
         $error("backing buffer smaller than one word");
      end
   endgenerate

   always_comb begin
      sz_ext    = {1'b0, size_i};
      sz_mask   = sz_ext - (AW+1)'(1);
      aligned   = (cur_q + sz_mask) & ~sz_mask;
      alloc_end = aligned + sz_ext;
      fit_o     = have_q && (alloc_end <= lim_q);
      addr_o    = aligned[AW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         lim_q  <= '0;
         have_q <= 1'b0;
      end else if (load_i) begin
         cur_q  <= {1'b0, load_base_i};
         lim_q  <= {1'b0, load_base_i} + BUF_SZ;
         have_q <= 1'b1;
      end else if (commit_i) begin
         cur_q  <= alloc_end;
      end
   end

   // the bump pointer never runs past the end of the current buffer
   assert_within_buffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      have_q |-> (cur_q <= lim_q));

   // a placement is only taken when the caller saw it fit
   assert_commit_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |-> fit_o);

endmodule

// File: rtl/aux_leaf_rule.sv
module aux_leaf_rule (
   input  logic        unmap_i,
   input  logic [63:0] cur_i,
   input  logic [63:0] new_i,
   output logic        wr_o,
   output logic [63:0] wdata_o,
   output logic        flag_o
);

   logic stale_used;

   always_comb begin
      stale_used = |cur_i[63:1];
      if (unmap_i) begin
         wr_o    = cur_i[0];
         wdata_o = {cur_i[63:1], 1'b0};
         flag_o  = cur_i[0] && !stale_used;
      end else begin
         wr_o    = !cur_i[0];
         wdata_o = new_i;
         flag_o  = !cur_i[0] && stale_used && ({cur_i[63:1], 1'b1} != new_i);
      end
   end

endmodule

// File: rtl/aux_map_updater.sv
module aux_map_updater
   import aux_upd_pkg::*;
#(
   parameter int unsigned AW             = 48,
   parameter int unsigned PAGE_LG        = 16,
   parameter int unsigned LEAF_IDX_W     = 8,
   parameter int unsigned MID_IDX_W      = 12,
   parameter int unsigned TOP_IDX_W      = 12,
   parameter int unsigned MID_TBL_BYTES  = 32768,
   parameter int unsigned LEAF_TBL_BYTES = 8192,
   parameter int unsigned BUF_BYTES      = 1048576,
   parameter int unsigned AUX_STRIDE     = 256,
   parameter int unsigned AUX_LO         = 8,
   parameter int unsigned FMT_W          = 12,
   parameter int unsigned LEN_W          = 32,
   parameter int unsigned CNT_W          = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic             cmd_unmap,
   input  logic [AW-1:0]    cmd_base,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic [AW-1:0]    cmd_aux,
   input  logic [FMT_W-1:0] cmd_fmt,
   output logic             done_o,
   output logic             err_o,
   output logic             flush_o,
   output logic [CNT_W-1:0] flush_cnt,
   output logic [AW-1:0]    root_base,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [63:0]      mem_wdata,
   input  logic [63:0]      mem_rdata,
   output logic             buf_req,
   input  logic             buf_gnt,
   input  logic [AW-1:0]    buf_base
);

   localparam int unsigned PN_W    = AW - PAGE_LG;
   localparam int unsigned AUXH_W  = AW - AUX_LO;
   localparam int unsigned GAP_W   = 64 - FMT_W - AW;
   localparam logic [AW-1:0] MID_SZ  = AW'(MID_TBL_BYTES);
   localparam logic [AW-1:0] LEAF_SZ = AW'(LEAF_TBL_BYTES);
   localparam logic [AW-1:0] MID_MASK  = ~(MID_SZ - AW'(1));
   localparam logic [AW-1:0] LEAF_MASK = ~(LEAF_SZ - AW'(1));
   localparam logic [LEN_W:0] PAGE_BYTES = (LEN_W+1)'(1) << PAGE_LG;
   localparam logic [AUXH_W-1:0] AUX_STEP = AUXH_W'(AUX_STRIDE >> AUX_LO);
   localparam logic [AW-1:0] WORD_STEP = AW'(WORD_BYTES);

   generate
      if (PAGE_LG + LEAF_IDX_W + MID_IDX_W + TOP_IDX_W != AW) begin : g_bad_split
         $error("index fields do not cover the address");
      end
      if (MID_TBL_BYTES < (WORD_BYTES << MID_IDX_W) ||
          MID_TBL_BYTES < (WORD_BYTES << TOP_IDX_W)) begin : g_bad_mid
         $error("root or middle table too small for its index");
      end
      if (LEAF_TBL_BYTES < (WORD_BYTES << LEAF_IDX_W)) begin : g_bad_leaf
         $error("leaf table too small for its index");
      end
      if ((MID_TBL_BYTES & (MID_TBL_BYTES - 1)) != 0 ||
          (LEAF_TBL_BYTES & (LEAF_TBL_BYTES - 1)) != 0) begin : g_bad_pow2
         $error("table sizes must be powers of two");
      end
      if (BUF_BYTES < MID_TBL_BYTES) begin : g_bad_buf
         $error("backing buffer cannot hold a middle table");
      end
      if (FMT_W + AW >= 64) begin : g_bad_fmt
         $error("format tag overlaps the address field");
      end
      if ((AUX_STRIDE % (1 << AUX_LO)) != 0) begin : g_bad_stride
         $error("aux stride must keep the low aux bits zero");
      end
   endgenerate

   upd_state_e        st_q;
   tbl_level_e        lvl_q;
   logic              unmap_q, flag_q;
   logic [FMT_W-1:0]  fmt_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W:0]    off_q, next_off;
   logic [PN_W-1:0]   pn_q;
   logic [AUXH_W-1:0] aux_q;
   logic [AW-1:0]     root_q, mid_q, leaf_q, tbl_q, clr_q;
   logic              done_q, err_q, flush_q;
   logic [CNT_W-1:0]  cnt_q;

   logic [TOP_IDX_W-1:0]  idx_top;
   logic [MID_IDX_W-1:0]  idx_mid;
   logic [LEAF_IDX_W-1:0] idx_leaf;
   logic [AW-1:0] top_ea, mid_ea, leaf_ea, tbl_sz, tbl_end;
   logic [63:0]   link_word, leaf_new;
   logic          misaligned;

   logic          alloc_fit, alloc_commit, alloc_load;
   logic [AW-1:0] alloc_addr;
   logic          rule_wr, rule_flag;
   logic [63:0]   rule_wdata;

   always_comb begin
      idx_leaf   = pn_q[LEAF_IDX_W-1:0];
      idx_mid    = pn_q[LEAF_IDX_W +: MID_IDX_W];
      idx_top    = pn_q[PN_W-1 -: TOP_IDX_W];
      top_ea     = root_q + (AW'(idx_top) << WORD_LG);
      mid_ea     = mid_q + (AW'(idx_mid) << WORD_LG);
      leaf_ea    = leaf_q + (AW'(idx_leaf) << WORD_LG);
      tbl_sz     = (lvl_q == LV_LEAF) ? LEAF_SZ : MID_SZ;
      tbl_end    = tbl_q + tbl_sz;
      link_word  = {{(64-AW){1'b0}}, tbl_q & ~(tbl_sz - AW'(1))} | 64'd1;
      leaf_new   = {fmt_q, {GAP_W{1'b0}}, aux_q, {(AUX_LO-1){1'b0}}, 1'b1};
      next_off   = off_q + PAGE_BYTES;
      misaligned = (|cmd_base[PAGE_LG-1:0]) || (|cmd_aux[AUX_LO-1:0]);
   end

   aux_bump_alloc #(
      .AW        (AW),
      .BUF_BYTES (BUF_BYTES)
   ) u_alloc (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (alloc_load),
      .load_base_i (buf_base),
      .size_i      (tbl_sz),
      .commit_i    (alloc_commit),
      .fit_o       (alloc_fit),
      .addr_o      (alloc_addr)
   );

   aux_leaf_rule u_rule (
      .unmap_i (unmap_q),
      .cur_i   (mem_rdata),
      .new_i   (leaf_new),
      .wr_o    (rule_wr),
      .wdata_o (rule_wdata),
      .flag_o  (rule_flag)
   );

   always_comb begin
      mem_req      = 1'b0;
      mem_we       = 1'b0;
      mem_addr     = '0;
      mem_wdata    = '0;
      buf_req      = 1'b0;
      alloc_commit = 1'b0;
      alloc_load   = 1'b0;
      unique case (st_q)
         ST_ALLOC: alloc_commit = alloc_fit;
         ST_BUF: begin
            buf_req    = 1'b1;
            alloc_load = buf_gnt;
         end
         ST_CLEAR: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = clr_q;
         end
         ST_LINK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = (lvl_q == LV_MID) ? top_ea : mid_ea;
            mem_wdata = link_word;
         end
         ST_RD_TOP: begin
            mem_req  = 1'b1;
            mem_addr = top_ea;
         end
         ST_RD_MID: begin
            mem_req  = 1'b1;
            mem_addr = mid_ea;
         end
         ST_RD_LEAF: begin
            mem_req  = 1'b1;
            mem_addr = leaf_ea;
         end
         ST_CK_LEAF: begin
            mem_req   = rule_wr;
            mem_we    = rule_wr;
            mem_addr  = leaf_ea;
            mem_wdata = rule_wdata;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_BOOT;
         lvl_q   <= LV_ROOT;
         unmap_q <= 1'b0;
         flag_q  <= 1'b0;
         fmt_q   <= '0;
         len_q   <= '0;
         off_q   <= '0;
         pn_q    <= '0;
         aux_q   <= '0;
         root_q  <= '0;
         mid_q   <= '0;
         leaf_q  <= '0;
         tbl_q   <= '0;
         clr_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         flush_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         flush_q <= 1'b0;
         unique case (st_q)
            ST_BOOT: begin
               lvl_q <= LV_ROOT;
               st_q  <= ST_ALLOC;
            end
            ST_ALLOC: begin
               if (alloc_fit) begin
                  tbl_q <= alloc_addr;
                  clr_q <= alloc_addr;
                  if (lvl_q == LV_ROOT) root_q <= alloc_addr;
                  st_q  <= ST_CLEAR;
               end else begin
                  st_q  <= ST_BUF;
               end
            end
            ST_BUF: if (buf_gnt) st_q <= ST_ALLOC;
            ST_CLEAR: begin
               clr_q <= clr_q + WORD_STEP;
               if (clr_q + WORD_STEP == tbl_end)
                  st_q <= (lvl_q == LV_ROOT) ? ST_IDLE : ST_LINK;
            end
            ST_LINK: begin
               if (lvl_q == LV_MID) begin
                  mid_q <= tbl_q;
                  st_q  <= ST_RD_MID;
               end else begin
                  leaf_q <= tbl_q;
                  st_q   <= ST_RD_LEAF;
               end
            end
            ST_IDLE: begin
               if (cmd_valid) begin
                  if (misaligned) begin
                     err_q  <= 1'b1;
                     done_q <= 1'b1;
                  end else if (cmd_len == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     unmap_q <= cmd_unmap;
                     len_q   <= cmd_len;
                     fmt_q   <= cmd_fmt;
                     pn_q    <= cmd_base[AW-1:PAGE_LG];
                     aux_q   <= cmd_aux[AW-1:AUX_LO];
                     off_q   <= '0;
                     flag_q  <= 1'b0;
                     st_q    <= ST_RD_TOP;
                  end
               end
            end
            ST_RD_TOP: st_q <= ST_CK_TOP;
            ST_CK_TOP: begin
               if (mem_rdata[0]) begin
                  mid_q <= mem_rdata[AW-1:0] & MID_MASK;
                  st_q  <= ST_RD_MID;
               end else if (unmap_q) begin
                  st_q  <= ST_STEP;
               end else begin
                  lvl_q <= LV_MID;
                  st_q  <= ST_ALLOC;
               end
            end
            ST_RD_MID: st_q <= ST_CK_MID;
            ST_CK_MID: begin
               if (mem_rdata[0]) begin
                  leaf_q <= mem_rdata[AW-1:0] & LEAF_MASK;
                  st_q   <= ST_RD_LEAF;
               end else if (unmap_q) begin
                  st_q   <= ST_STEP;
               end else begin
                  lvl_q  <= LV_LEAF;
                  st_q   <= ST_ALLOC;
               end
            end
            ST_RD_LEAF: st_q <= ST_CK_LEAF;
            ST_CK_LEAF: begin
               flag_q <= flag_q | rule_flag;
               st_q   <= ST_STEP;
            end
            ST_STEP: begin
               if (next_off < {1'b0, len_q}) begin
                  off_q <= next_off;
                  pn_q  <= pn_q + PN_W'(1);
                  aux_q <= aux_q + AUX_STEP;
                  st_q  <= ST_RD_TOP;
               end else begin
                  done_q  <= 1'b1;
                  flush_q <= flag_q;
                  cnt_q   <= cnt_q + CNT_W'(flag_q);
                  st_q    <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_ready = (st_q == ST_IDLE);
   assign done_o    = done_q;
   assign err_o     = err_q;
   assign flush_o   = flush_q;
   assign flush_cnt = cnt_q;
   assign root_base = root_q;

   // a rejected command leaves memory alone and finishes at once
   assert_reject_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!mem_req && done_o));

   // the flush pulse only appears together with command completion
   assert_flush_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> done_o);

   // the counter moves by exactly the flush pulse at completion
   assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (flush_cnt == $past(flush_cnt) + CNT_W'(flush_o)));

   // a pending buffer request is not withdrawn before the grant
   assert_buf_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_req && !buf_gnt) |=> buf_req);

   // while ready for a command, no memory or buffer traffic is issued
   assert_ready_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!mem_req && !buf_req));

endmodule

// File: tb/aux_map_updater_tb.sv
`timescale 1ns/1ps
module aux_map_updater_tb;

   localparam longint unsigned BUFSZ   = 64'h1_0000;
   localparam longint unsigned BASE0   = 64'h10_0000_0000;
   localparam longint unsigned SPACING = 64'h10_0000;
   localparam longint unsigned PAGE    = 64'h1_0000;
   localparam longint unsigned STRIDE  = 256;
   localparam longint unsigned MIDSZ   = 32768;
   localparam longint unsigned LEAFSZ  = 8192;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_unmap = 1'b0;
   logic [47:0] cmd_base = '0;
   logic [31:0] cmd_len = '0;
   logic [47:0] cmd_aux = '0;
   logic [11:0] cmd_fmt = '0;
   logic        done_o, err_o, flush_o;
   logic [15:0] flush_cnt;
   logic [47:0] root_base;
   logic        mem_req, mem_we;
   logic [47:0] mem_addr;
   logic [63:0] mem_wdata;
   logic [63:0] mem_rdata = '0;
   logic        buf_req;
   logic        buf_gnt = 1'b0;
   logic [47:0] buf_base = '0;

   always #2 clk = ~clk;

   aux_map_updater #(.BUF_BYTES(65536)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_unmap(cmd_unmap),
      .cmd_base(cmd_base), .cmd_len(cmd_len), .cmd_aux(cmd_aux), .cmd_fmt(cmd_fmt),
      .done_o(done_o), .err_o(err_o), .flush_o(flush_o), .flush_cnt(flush_cnt),
      .root_base(root_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .buf_req(buf_req), .buf_gnt(buf_gnt), .buf_base(buf_base)
   );

   // memory and buffer environment
   logic [63:0] mem [longint unsigned];
   longint unsigned wr_cnt = 0;
   longint unsigned env_nb = 0;

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            mem[longint'(mem_addr)] = mem_wdata;
            wr_cnt = wr_cnt + 1;
         end else begin
            mem_rdata <= mem.exists(longint'(mem_addr)) ? mem[longint'(mem_addr)]
                                                        : 64'hBAD0_BAD0_BAD0_BAD1;
         end
      end
      if (buf_req && !buf_gnt) begin
         longint unsigned b;
         b = BASE0 + env_nb * SPACING;
         for (longint unsigned k = 0; k < BUFSZ / 8; k++)
            mem[b + 8 * k] = 64'hA5A5_0000_0000_0000 | k;
         buf_base <= b[47:0];
         buf_gnt  <= 1'b1;
         env_nb = env_nb + 1;
      end else begin
         buf_gnt <= 1'b0;
      end
   end

   // reference model
   logic [63:0] ref_m [longint unsigned];
   longint unsigned r_cur = 0, r_lim = 0, r_nb = 0, r_root = 0;
   bit              r_have = 0;
   longint unsigned exp_w;
   bit              exp_flag, exp_err;
   int unsigned     m_cnt = 0;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   function automatic logic [63:0] rd(input longint unsigned a);
      return ref_m.exists(a) ? ref_m[a] : 64'd0;
   endfunction

   task automatic m_alloc(input longint unsigned sz, output longint unsigned a);
      longint unsigned al;
      al = (r_cur + sz - 1) & ~(sz - 1);
      if (!r_have || al + sz > r_lim) begin
         r_cur  = BASE0 + r_nb * SPACING;
         r_lim  = r_cur + BUFSZ;
         r_have = 1;
         r_nb   = r_nb + 1;
         al     = r_cur;
      end
      a = al;
      r_cur = al + sz;
      for (longint unsigned i = 0; i < sz / 8; i++) ref_m[al + 8 * i] = 64'd0;
      exp_w = exp_w + sz / 8;
   endtask

   task automatic m_cmd(input bit un, input longint unsigned base, input longint unsigned len,
                        input longint unsigned aux, input logic [11:0] fmt);
      longint unsigned te, me, le, t, mb, lb, ax, pg, nw;
      logic [63:0] cur;
      exp_w = 0; exp_flag = 0; exp_err = 0;
      if ((base & 64'hFFFF) != 0 || (aux & 64'hFF) != 0) begin
         exp_err = 1;
         return;
      end
      for (longint unsigned off = 0; off < len; off += PAGE) begin
         pg = base + off;
         ax = aux + (off / PAGE) * STRIDE;
         te = r_root + ((pg >> 36) & 64'hFFF) * 8;
         if (rd(te)[0] == 1'b0) begin
            if (un) continue;
            m_alloc(MIDSZ, t);
            ref_m[te] = (t & 64'h0000_FFFF_FFFF_8000) | 1;
            exp_w++;
         end
         mb = rd(te) & 64'h0000_FFFF_FFFF_8000;
         me = mb + ((pg >> 24) & 64'hFFF) * 8;
         if (rd(me)[0] == 1'b0) begin
            if (un) continue;
            m_alloc(LEAFSZ, t);
            ref_m[me] = (t & 64'h0000_FFFF_FFFF_E000) | 1;
            exp_w++;
         end
         lb  = rd(me) & 64'h0000_FFFF_FFFF_E000;
         le  = lb + ((pg >> 16) & 64'hFF) * 8;
         cur = rd(le);
         if (un) begin
            if (cur[0]) begin
               if ((cur >> 1) == 0) exp_flag = 1;
               ref_m[le] = cur & ~64'd1;
               exp_w++;
            end
         end else if (!cur[0]) begin
            nw = (longint'(fmt) << 52) | (ax & 64'h0000_FFFF_FFFF_FF00) | 1;
            if ((cur >> 1) != 0 && (cur | 1) != nw) exp_flag = 1;
            ref_m[le] = nw;
            exp_w++;
         end
      end
      if (exp_flag) m_cnt++;
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input longint unsigned act, input longint unsigned exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic cmp_mem(input string req);
      int bad = 0;
      longint unsigned fk = 0, fa = 0, fe = 0;
      foreach (ref_m[k]) begin
         logic [63:0] v;
         v = mem.exists(k) ? mem[k] : 64'hBAD0_BAD0_BAD0_BAD1;
         if (v !== ref_m[k]) begin
            if (bad == 0) begin fk = k; fa = v; fe = ref_m[k]; end
            bad++;
         end
      end
      check(bad == 0, req, $sformatf("table word at 0x%0h", fk), fa, fe);
   endtask

   task automatic run_cmd(input bit un, input longint unsigned base, input longint unsigned len,
                          input longint unsigned aux, input logic [11:0] fmt, input string req);
      longint unsigned w0;
      bit got_flush, got_err, seen;
      int guard = 0;
      m_cmd(un, base, len, aux, fmt);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      w0 = wr_cnt;
      cmd_unmap = un; cmd_base = base[47:0]; cmd_len = len[31:0];
      cmd_aux = aux[47:0]; cmd_fmt = fmt; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      seen = done_o;
      while (!seen && guard < 50000) begin
         @(negedge clk);
         seen = done_o;
         guard++;
      end
      got_flush = flush_o;
      got_err   = err_o;
      check(seen, req, "done pulse seen", longint'(seen), 1);
      check(wr_cnt - w0 == exp_w, req, "memory writes", wr_cnt - w0, exp_w);
      check(got_flush == exp_flag, req, "flush pulse", longint'(got_flush), longint'(exp_flag));
      check(got_err == exp_err, req, "error flag", longint'(got_err), longint'(exp_err));
      check(flush_cnt == 16'(m_cnt), "R10", "flush count", longint'(flush_cnt), longint'(m_cnt));
      cmp_mem(req);
   endtask

   localparam longint unsigned A = 64'h0012_3400_0000;
   localparam longint unsigned Z = 64'h0A00_0000_0000;
   localparam longint unsigned X = 64'h20_0000_0000;

   initial begin
      exp_w = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: not ready while the root table is being built
      check(!cmd_ready, "R1", "ready during boot", longint'(cmd_ready), 0);
      m_alloc(MIDSZ, r_root);
      while (!cmd_ready) @(negedge clk);
      check(root_base == r_root[47:0], "R1", "root address", longint'(root_base), r_root);
      check(wr_cnt == exp_w, "R1", "root clear writes", wr_cnt, exp_w);
      check(flush_cnt == 0 && !done_o, "R1", "idle after boot", longint'(flush_cnt), 0);
      cmp_mem("R1");

      // R2 R3 R4 R5: fresh region, middle fills first buffer, leaf needs a second
      run_cmd(0, A, 3 * PAGE, X, 12'hABC, "R3");
      // R6: same install again leaves valid leaves untouched
      run_cmd(0, A, 3 * PAGE, X, 12'hABC, "R6");
      // R8: remove two pages, payload kept
      run_cmd(1, A, 2 * PAGE, X, 12'h000, "R8");
      // R7: reinstall first page with a different aux address
      run_cmd(0, A, PAGE, 64'h30_0000_0000, 12'hABC, "R7");
      // R7: reinstall second page with identical content
      run_cmd(0, A + PAGE, PAGE, X + STRIDE, 12'hABC, "R7");
      // R11: misaligned base and misaligned aux
      run_cmd(0, A + 64'h100, PAGE, X, 12'h123, "R11");
      run_cmd(0, A, PAGE, X + 64'h80, 12'h123, "R11");
      // R8: removal where the top entry was never populated
      run_cmd(1, 64'h0500_0000_0000, 2 * PAGE, 0, 12'h000, "R8");
      // R5: padding inside the second buffer and a third buffer for the leaf
      run_cmd(0, Z, PAGE, 0, 12'h000, "R5");
      // R9: removing an all-zero payload
      run_cmd(1, Z, PAGE, 0, 12'h000, "R9");
      // R7: all-zero stale leaf gives no flush
      run_cmd(0, Z, PAGE, 0, 12'h000, "R7");
      // R2 R12: length not a page multiple covers a partial last page
      run_cmd(0, A + 3 * PAGE, PAGE + 1, X + 64'h1000, 12'h5A5, "R2");

      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(4 * 190000);
      if (!finished) begin
         finished = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule